// File: doc/BRIEF.md
# Dual-Channel Phase-Mode Clock Generator

This block produces the cycle-start ticks for two synchronous buck PWM channels. Both channels share one free-running master counter that wraps every `PERIOD` reference ticks. Channel 1 starts its cycle when the counter wraps. Channel 2 starts its cycle at an offset of 0, `PERIOD/4` or `PERIOD/2` ticks after that point. The offset is chosen from a memory-mode pin and a strap that tells whether the converters are fed from a battery-class source or from a 5 V system rail.

The block also gives each channel a flag that permits light-load hysteretic operation. A channel is held in fixed-frequency PWM until its soft-start has completed. Channel 2 is never permitted to enter hysteretic operation while memory mode is selected.

A new offset is sampled only at the counter wrap. Because of this, a change of pin or strap never shortens or doubles a channel-2 cycle.

Top module: `pwm_phase_clkgen`

## Requirements
- R1: While `rst_n` is low and on the clock edge that samples it low, the counter returns to zero and both `cyc_start1` and `cyc_start2` stay low. After reset is released, the first `cyc_start1` pulse appears exactly `PERIOD` clock cycles after the first rising edge that samples `rst_n` high.
- R2: `cyc_start1` is high for exactly one clock cycle and repeats every `PERIOD` cycles.
- R3: With `mem_mode` = 0 (independent regulators), `cyc_start2` rises `PERIOD/2` cycles (rounded down) after `cyc_start1`.
- R4: With `mem_mode` = 1 and `src_rail5v` = 0 (battery-class input), `cyc_start2` is high in the same cycle as `cyc_start1`.
- R5: With `mem_mode` = 1 and `src_rail5v` = 1 (5 V rail input), `cyc_start2` rises `PERIOD/4` cycles (rounded down) after `cyc_start1`.
- R6: The offset uses the values of `mem_mode` and `src_rail5v` sampled on the clock edge at which the counter wraps, which is the edge that raises `cyc_start1`. Between two consecutive `cyc_start1` pulses there is exactly one `cyc_start2` pulse, counting a pulse that coincides with the later `cyc_start1` as belonging to the next period.
- R7: `hyst_ok1` is high only while `ss_done1` is high.
- R8: `hyst_ok2` is high only while `ss_done2` is high and `mem_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick of the switching period |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_mode | input | 1 | 1 = memory-supply pairing; 0 = two independent regulators |
| src_rail5v | input | 1 | Input-source strap: 1 = 5 V system rail, 0 = battery-class source |
| ss_done1 | input | 1 | Soft-start complete, channel 1 |
| ss_done2 | input | 1 | Soft-start complete, channel 2 |
| cyc_start1 | output | 1 | Single-tick cycle start, channel 1 |
| cyc_start2 | output | 1 | Single-tick cycle start, channel 2 |
| hyst_ok1 | output | 1 | Hysteretic operation permitted, channel 1 |
| hyst_ok2 | output | 1 | Hysteretic operation permitted, channel 2 |

## Verification
A corrupted counter shows up at the next wrap: the channel-1 tick appears at the wrong point or not at all, and the bench sees that within one period.

A wrongly latched offset moves the channel-2 tick to the wrong point. A missing latch lets channel 2 fire twice, or not at all, in the period in which the mode pin changes mid-period. Both errors are visible before the next channel-1 tick.

The permission flags are pure gating of current inputs, so any error there appears in the same cycle as the input change that exposes it.

// File: rtl/pwm_phase_pkg.sv
// Package: shared types and the phase-offset decode for the dual-channel clock generator.
// Assumes the encodings: mem_mode=0 -> half period, mem_mode=1 with a 5 V rail -> quarter period,
// mem_mode=1 with a battery-class source -> aligned.
package pwm_phase_pkg;

    typedef enum logic [1:0] {
        PH_ALIGN   = 2'd0,
        PH_QUARTER = 2'd1,
        PH_HALF    = 2'd2
    } phase_sel_e;

    // Map the mode pin and the source strap to a phase relation.
    function automatic phase_sel_e decode_phase(input logic mem_mode, input logic src_rail5v);
        if (!mem_mode)      return PH_HALF;
        else if (src_rail5v) return PH_QUARTER;
        else                 return PH_ALIGN;
    endfunction

endpackage

// File: rtl/pwm_phase_counter.sv
// Module: master period counter.
// Counts 0..PERIOD-1 and wraps. It raises run_q at the first wrap after reset, so that
// the partial period right after reset produces no cycle-start ticks.
// Assumes PERIOD >= 4.
module pwm_phase_counter #(
    parameter int PERIOD = 40,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_q,
    output logic          wrap,
    output logic          run_q
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    assign wrap = (cnt_q == LAST);

    // Advance the counter and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // Enable tick generation from the first complete period onwards.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 1'b0;
        else if (wrap) run_q <= 1'b1;
    end
endmodule

// File: rtl/pwm_phase_offset.sv
// Module: channel-2 offset register.
// Samples the phase selection only on the wrap edge and holds it for the whole period that follows.
// Assumes the offsets are PERIOD/4 and PERIOD/2, rounded down. After reset it defaults to half a period.
module pwm_phase_offset
    import pwm_phase_pkg::*;
#(
    parameter int PERIOD = 40,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic          mem_mode,
    input  logic          src_rail5v,
    output logic [CW-1:0] off_q
);
    localparam logic [CW-1:0] OFF_QTR  = CW'(PERIOD / 4);
    localparam logic [CW-1:0] OFF_HALF = CW'(PERIOD / 2);

    phase_sel_e       sel;
    logic [CW-1:0]    off_d;

    // Translate the decoded phase relation into a tick offset.
    always_comb begin
        sel = decode_phase(mem_mode, src_rail5v);
        unique case (sel)
            PH_ALIGN:   off_d = '0;
            PH_QUARTER: off_d = OFF_QTR;
            default:    off_d = OFF_HALF;
        endcase
    end

    // Take the new offset only at a period boundary, so no cycle is shortened.
    always_ff @(posedge clk) begin
        if (!rst_n)    off_q <= OFF_HALF;
        else if (wrap) off_q <= off_d;
    end
endmodule

// File: rtl/pwm_hyst_gate.sv
// Module: hysteretic-permission gating for NCH channels.
// A channel may leave forced PWM only after its soft-start has completed. A channel whose
// block bit is set never leaves forced PWM. Pure combinational gating of current inputs.
module pwm_hyst_gate #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] ss_done,
    input  logic [NCH-1:0] block,
    output logic [NCH-1:0] allow
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Permission requires completed soft-start and no blocking condition.
        always_comb allow[g] = ss_done[g] & ~block[g];
    end
endmodule

// File: rtl/pwm_phase_clkgen.sv
// Module: dual-channel phase-mode clock generator (top).
// Produces one single-tick cycle start per channel per PERIOD ticks. Channel 2 is offset from
// channel 1 by 0, PERIOD/4 or PERIOD/2, as selected by mem_mode and src_rail5v at each wrap.
// Also produces the hysteretic-permission flags.
// Assumes PERIOD >= 4 and inputs synchronous to clk.
module pwm_phase_clkgen #(
    parameter int PERIOD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mem_mode,
    input  logic src_rail5v,
    input  logic ss_done1,
    input  logic ss_done2,
    output logic cyc_start1,
    output logic cyc_start2,
    output logic hyst_ok1,
    output logic hyst_ok2
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] off_q;
    logic          wrap;
    logic          run_q;
    logic [1:0]    allow;

    pwm_phase_counter #(.PERIOD(PERIOD)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (cnt_q),
        .wrap  (wrap),
        .run_q (run_q)
    );

    pwm_phase_offset #(.PERIOD(PERIOD)) u_off (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .mem_mode   (mem_mode),
        .src_rail5v (src_rail5v),
        .off_q      (off_q)
    );

    pwm_hyst_gate #(.NCH(2)) u_hyst (
        .ss_done ({ss_done2, ss_done1}),
        .block   ({mem_mode, 1'b0}),
        .allow   (allow)
    );

    // Decode the counter phase into the two cycle-start ticks.
    always_comb begin
        cyc_start1 = run_q && (cnt_q == '0);
        cyc_start2 = run_q && (cnt_q == off_q);
    end

    assign hyst_ok1 = allow[0];
    assign hyst_ok2 = allow[1];
endmodule

// File: rtl/pwm_phase_clkgen_chk.sv
// Checker: observes the clock generator ports and flags timing or gating violations.
// Assumes it is bound to pwm_phase_clkgen with the same PERIOD.
module pwm_phase_clkgen_chk #(
    parameter int PERIOD = 40
) (
    input logic clk,
    input logic rst_n,
    input logic mem_mode,
    input logic src_rail5v,
    input logic ss_done1,
    input logic ss_done2,
    input logic cyc_start1,
    input logic cyc_start2,
    input logic hyst_ok1,
    input logic hyst_ok2
);
    logic [31:0] gap_q;
    logic [1:0]  c2_q;
    logic        seen_q;

    // Track the distance since the last channel-1 tick and the channel-2 ticks seen in that period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            c2_q   <= '0;
            seen_q <= 1'b0;
        end else if (cyc_start1) begin
            gap_q  <= '0;
            c2_q   <= {1'b0, cyc_start2};
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1;
            c2_q   <= (c2_q == 2'd3) ? c2_q : c2_q + {1'b0, cyc_start2};
        end
    end

    AST_RST_QUIET:   assert property (@(posedge clk) !rst_n |=> (!cyc_start1 && !cyc_start2)); // R1
    AST_C1_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) cyc_start1 |=> !cyc_start1); // R2
    AST_C1_PERIOD:   assert property (@(posedge clk) disable iff (!rst_n) (cyc_start1 && seen_q) |-> (gap_q == 32'(PERIOD - 1))); // R2
    AST_C2_ONCE:     assert property (@(posedge clk) disable iff (!rst_n) (cyc_start1 && seen_q) |-> (c2_q == 2'd1)); // R6
    AST_ALIGN_PAIR:  assert property (@(posedge clk) disable iff (!rst_n) (cyc_start1 && $past(mem_mode) && !$past(src_rail5v)) |-> cyc_start2); // R4
    AST_HYST1_SS:    assert property (@(posedge clk) disable iff (!rst_n) !ss_done1 |-> !hyst_ok1); // R7
    AST_HYST2_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (mem_mode || !ss_done2) |-> !hyst_ok2); // R8
endmodule

bind pwm_phase_clkgen pwm_phase_clkgen_chk #(.PERIOD(PERIOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_mode   (mem_mode),
    .src_rail5v (src_rail5v),
    .ss_done1   (ss_done1),
    .ss_done2   (ss_done2),
    .cyc_start1 (cyc_start1),
    .cyc_start2 (cyc_start2),
    .hyst_ok1   (hyst_ok1),
    .hyst_ok2   (hyst_ok2)
);

// File: tb/pwm_phase_clkgen_tb_top.sv
// Bench: scoreboard for the dual-channel clock generator.
// The model process pushes the expected outputs at each rising edge; the monitor pops them
// 2 ns later and compares them with the design outputs.
module pwm_phase_clkgen_tb_top;
    localparam int PERIOD = 40;
    localparam int QTR    = PERIOD / 4;
    localparam int HALF   = PERIOD / 2;

    typedef struct {
        logic p1, p2, h1, h2;
        int   off;
        bit   early;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_mode = 1'b0;
    logic src_rail5v = 1'b0;
    logic ss_done1 = 1'b0;
    logic ss_done2 = 1'b0;
    logic cyc_start1, cyc_start2, hyst_ok1, hyst_ok2;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    pwm_phase_clkgen #(.PERIOD(PERIOD)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_mode   (mem_mode),
        .src_rail5v (src_rail5v),
        .ss_done1   (ss_done1),
        .ss_done2   (ss_done2),
        .cyc_start1 (cyc_start1),
        .cyc_start2 (cyc_start2),
        .hyst_ok1   (hyst_ok1),
        .hyst_ok2   (hyst_ok2)
    );

    // Model: ticks since reset release and the offset sampled at each wrap.
    int n = 0;
    int m_off = HALF;
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            n = 0;
            m_off = HALF;
        end else begin
            n++;
            if (n % PERIOD == 0)
                m_off = !mem_mode ? HALF : (src_rail5v ? QTR : 0);
        end
        e.p1    = rst_n && (n >= PERIOD) && (n % PERIOD == 0);
        e.p2    = rst_n && (n >= PERIOD) && (n % PERIOD == m_off);
        e.h1    = ss_done1;
        e.h2    = ss_done2 && !mem_mode;
        e.off   = m_off;
        e.early = (n <= PERIOD);
        q.push_back(e);
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare against the scoreboard and count channel-2 ticks per period (R6).
    int  c2 = 0;
    bit  seen = 1'b0;
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(e.early ? "R1 cyc_start1" : "R2 cyc_start1", cyc_start1, e.p1);
            check(e.early ? "R1 cyc_start2" :
                  (e.off == HALF ? "R3 cyc_start2" : (e.off == QTR ? "R5 cyc_start2" : "R4 cyc_start2")),
                  cyc_start2, e.p2);
            check("R7 hyst_ok1", hyst_ok1, e.h1);
            check("R8 hyst_ok2", hyst_ok2, e.h2);
            if (!rst_n) begin
                c2 = 0;
                seen = 1'b0;
            end else begin
                if (cyc_start1) begin
                    if (seen) begin
                        checks++;
                        if (c2 != 1) begin
                            fails++;
                            $display("FAIL R6 ch2 ticks per period actual=%0d expected=1", c2);
                        end
                    end
                    seen = 1'b1;
                    c2 = 0;
                end
                if (cyc_start2) c2++;
            end
        end
    end

    task automatic idle(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    // Driver: stimulus sequence covering every phase mode and the mid-period changes.
    initial begin
        idle(3);
        rst_n = 1'b1;                       // R1: first tick PERIOD cycles later
        idle(3 * PERIOD);                   // R3: independent regulators
        ss_done1 = 1'b1;                    // R7
        idle(7);
        ss_done2 = 1'b1;                    // R8: allowed while mem_mode low
        idle(PERIOD);
        mem_mode = 1'b1;                    // R4, R6, R8: applies at next wrap
        idle(3 * PERIOD + 5);
        src_rail5v = 1'b1;                  // R5 (changed mid-period, R6)
        idle(3 * PERIOD);
        ss_done1 = 1'b0;                    // R7 withdrawn
        idle(PERIOD / 2 + 3);
        mem_mode = 1'b0;                    // back to half period, changed after the quarter tick (R6)
        idle(2 * PERIOD);
        mem_mode = 1'b1;
        src_rail5v = 1'b0;                  // aligned again, changed mid-period
        idle(2 * PERIOD + 11);
        rst_n = 1'b0;                       // R1: mid-run reset
        idle(4);
        rst_n = 1'b1;
        idle(3 * PERIOD);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule